// File: doc/BRIEF.md
# Flash Write Status Flag Generator

This block forms the status byte that a flash array returns on a read while an embedded program or erase is running, has timed out, or is paused by an erase suspend. It takes the current operation type, the suspend state, a timeout flag, two address qualifiers for the read, the most significant bit of the byte being programmed, and the array data. On each read it latches either a status word or the array data. Two toggle flip-flops give a host a way to poll without knowing the address being written.

The first toggle advances on every read while an operation is active. The second advances only on reads that the status table marks as toggling bit 2. Polling on bit 7 returns the complement of the programmed data's top bit until the operation ends. Here, the algorithm controller simply lowers the operation input. Reads are plain strobes rather than a stream. There is no back-pressure: a read is taken in the cycle its strobe is first seen high, and the result is always accepted.

Top module: `flash_status_flags`

## Requirements
- R1: After reset, `dq` is 0 and `dq_valid` is 0.
- R2: A read is the first cycle in which `rd_strobe` is high after being low. `dq` and `dq_valid` change one clock after that cycle, and `dq_valid` is high for exactly one cycle per read.
- R3: With `op` = 0 (idle) or 3 (reserved, treated as idle), a read returns `array_data` unchanged.
- R4: With `op` = 1 (program) and `suspended` low, a read returns bit7 = NOT `prog_msb`, bit6 = toggle A, bit5 = `timeout`, bit3 = 0, bit2 = 1.
- R5: With `op` = 2 (erase) and `suspended` low, a read returns bit7 = 0, bit6 = toggle A, bit5 = `timeout`, bit3 = 1, bit2 = toggle B.
- R6: Toggle A inverts after every read while `op` is 1 or 2, whatever the address. The first read after an operation begins sees 0.
- R7: With `op` = 2 and `suspended` high, a read with `in_susp_sector` high returns bit7 = 1, bit6 = 1, bit5 = 0, bit3 = 0, bit2 = toggle B, and toggle B then inverts.
- R8: With `op` = 2 and `suspended` high, a read with `in_susp_sector` low returns `array_data`.
- R9: With `op` = 1 and `suspended` high, a read returns bit7 = NOT `prog_msb`, bit6 = toggle A, bit5 = `timeout`, bit3 = 0. Bit2 is 1 when `at_prog_addr` is high. Otherwise, bit2 is toggle B when `in_susp_sector` is high, and toggle B then inverts. In all other cases bit2 is 1.
- R10: `timeout` appears on bit5 in the program and running erase patterns and has no effect on array data reads.
- R11: In every status pattern, bits 4, 1 and 0 are 0.
- R12: A cycle in which `op` differs from its value in the previous cycle clears both toggles. A read in that same cycle sees both toggles as 0, and they then invert as usual.
- R13: Toggle B is unchanged by reads during a plain program, by reads of data, and by reads at the programmed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 2 | Operation: 0 idle, 1 program, 2 erase, 3 idle |
| suspended | input | 1 | Erase suspend is in force |
| timeout | input | 1 | Operation exceeded its time limit |
| in_susp_sector | input | 1 | Read address lies in the erase-suspended sector |
| at_prog_addr | input | 1 | Read address equals the address being programmed |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| array_data | input | DATA_W | Array contents at the read address |
| rd_strobe | input | 1 | Read strobe, taken on its rising level |
| dq | output | DATA_W | Latched read result |
| dq_valid | output | 1 | One-cycle pulse marking a new `dq` |

## Verification
Every result of this block is due exactly one clock after the edge that first samples `rd_strobe` high. This holds for `dq`, `dq_valid`, and the toggle state, which shows up only on the next read. The bench changes inputs and raises the strobe on a falling edge. It lowers the strobe on the following falling edge and checks `dq` and `dq_valid` there, half a period after the capturing edge. It then checks one falling edge later that `dq_valid` has dropped. Toggle expectations come from a bench model that sees only the port values.

// File: rtl/flagsgen_pkg.sv
package flagsgen_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  localparam int POLL_BIT = 7;
  localparam int TOGA_BIT = 6;
  localparam int TOUT_BIT = 5;
  localparam int ERAS_BIT = 3;
  localparam int TOGB_BIT = 2;
endpackage

// File: rtl/flagsgen_toggle.sv
module flagsgen_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic q_eff,
  output logic q
);
  always_comb q_eff = clr ? 1'b0 : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_eff ^ flip;
  end

  // R12
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !flip) |=> !q);
  // R12
  clr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && flip) |=> q);
  // R6
  flip_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && flip) |=> (q != $past(q)));
  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !flip) |=> $stable(q));
endmodule

// File: rtl/flagsgen_compose.sv
module flagsgen_compose
  import flagsgen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic              suspended,
  input  logic              timeout,
  input  logic              in_susp_sector,
  input  logic              at_prog_addr,
  input  logic              prog_msb,
  input  logic [DATA_W-1:0] array_data,
  input  logic              tog_a,
  input  logic              tog_b,
  output logic [DATA_W-1:0] word,
  output logic              flip_a,
  output logic              flip_b
);
  logic busy;
  always_comb busy = (op == OP_PROG) || (op == OP_ERASE);

  always_comb begin
    word   = '0;
    flip_a = busy;
    flip_b = 1'b0;
    unique case (op)
      OP_PROG: begin
        word[POLL_BIT] = ~prog_msb;
        word[TOGA_BIT] = tog_a;
        word[TOUT_BIT] = timeout;
        word[TOGB_BIT] = 1'b1;
        if (suspended && !at_prog_addr && in_susp_sector) begin
          word[TOGB_BIT] = tog_b;
          flip_b         = 1'b1;
        end
      end
      OP_ERASE: begin
        if (!suspended) begin
          word[TOGA_BIT] = tog_a;
          word[TOUT_BIT] = timeout;
          word[ERAS_BIT] = 1'b1;
          word[TOGB_BIT] = tog_b;
          flip_b         = 1'b1;
        end else if (in_susp_sector) begin
          word[POLL_BIT] = 1'b1;
          word[TOGA_BIT] = 1'b1;
          word[TOGB_BIT] = tog_b;
          flip_b         = 1'b1;
        end else begin
          word = array_data;
        end
      end
      default: word = array_data;
    endcase
  end
endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
  import flagsgen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op,
  input  logic              suspended,
  input  logic              timeout,
  input  logic              in_susp_sector,
  input  logic              at_prog_addr,
  input  logic              prog_msb,
  input  logic [DATA_W-1:0] array_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] dq,
  output logic              dq_valid
);
  op_e               op_cur;
  op_e               op_q;
  logic              rd_q;
  logic              rd_rise;
  logic              start;
  logic              tog_a_eff, tog_a_q, tog_b_eff, tog_b_q;
  logic              flip_a, flip_b;
  logic [DATA_W-1:0] word;

  always_comb begin
    op_cur  = op_e'(op);
    rd_rise = rd_strobe && !rd_q;
    start   = (op_cur != op_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      rd_q     <= 1'b0;
      dq       <= '0;
      dq_valid <= 1'b0;
    end else begin
      op_q     <= op_cur;
      rd_q     <= rd_strobe;
      dq_valid <= rd_rise;
      if (rd_rise) dq <= word;
    end
  end

  flagsgen_toggle u_tog_a (
    .clk(clk), .rst_n(rst_n), .clr(start), .flip(rd_rise && flip_a),
    .q_eff(tog_a_eff), .q(tog_a_q)
  );

  flagsgen_toggle u_tog_b (
    .clk(clk), .rst_n(rst_n), .clr(start), .flip(rd_rise && flip_b),
    .q_eff(tog_b_eff), .q(tog_b_q)
  );

  flagsgen_compose #(.DATA_W(DATA_W)) u_compose (
    .op(op_cur), .suspended(suspended), .timeout(timeout),
    .in_susp_sector(in_susp_sector), .at_prog_addr(at_prog_addr),
    .prog_msb(prog_msb), .array_data(array_data),
    .tog_a(tog_a_eff), .tog_b(tog_b_eff),
    .word(word), .flip_a(flip_a), .flip_b(flip_b)
  );

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |=> !dq_valid);
  // R2
  valid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_q) |=> dq_valid);
  // R4
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && op_cur == OP_PROG) |=> (dq[POLL_BIT] == !$past(prog_msb)));
  // R5
  erase_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && op_cur == OP_ERASE && !suspended) |=> (dq[ERAS_BIT] && !dq[POLL_BIT]));
  // R7
  susp_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && op_cur == OP_ERASE && suspended && in_susp_sector)
      |=> (dq[POLL_BIT] && dq[TOGA_BIT] && !dq[TOUT_BIT] && !dq[ERAS_BIT]));
  // R3
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && (op_cur == OP_IDLE || op_cur == OP_RSVD)) |=> (dq == $past(array_data)));
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && (op_cur == OP_PROG || (op_cur == OP_ERASE && (!suspended || in_susp_sector))))
      |=> (dq[4] == 1'b0 && dq[1:0] == 2'b00));
  // R10
  tout_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && (op_cur == OP_PROG || (op_cur == OP_ERASE && !suspended)))
      |=> (dq[TOUT_BIT] == $past(timeout)));
endmodule

// File: tb/flash_status_flags_test.sv
module flash_status_flags_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'd0;
  logic       suspended = 1'b0, timeout = 1'b0, in_susp_sector = 1'b0;
  logic       at_prog_addr = 1'b0, prog_msb = 1'b0, rd_strobe = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] dq;
  logic       dq_valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic       m_a = 1'b0, m_b = 1'b0;
  logic [1:0] m_prev_op = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_flags #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .suspended(suspended), .timeout(timeout),
    .in_susp_sector(in_susp_sector), .at_prog_addr(at_prog_addr),
    .prog_msb(prog_msb), .array_data(array_data), .rd_strobe(rd_strobe),
    .dq(dq), .dq_valid(dq_valid)
  );

  function automatic logic [7:0] exp_word(input logic [1:0] o, input logic s, input logic t,
      input logic ins, input logic atp, input logic pm, input logic [7:0] arr,
      input logic a, input logic b);
    logic [7:0] w = 8'h00;
    if (o == 2'd1) begin
      w[7] = ~pm; w[6] = a; w[5] = t; w[2] = 1'b1;
      if (s && !atp && ins) w[2] = b;
    end else if (o == 2'd2 && !s) begin
      w[6] = a; w[5] = t; w[3] = 1'b1; w[2] = b;
    end else if (o == 2'd2 && ins) begin
      w[7] = 1'b1; w[6] = 1'b1; w[2] = b;
    end else begin
      w = arr;
    end
    return w;
  endfunction

  function automatic logic flip_b_of(input logic [1:0] o, input logic s, input logic ins,
      input logic atp);
    if (o == 2'd2 && !s) return 1'b1;
    if (o == 2'd2 && s && ins) return 1'b1;
    if (o == 2'd1 && s && ins && !atp) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic s, input logic ins);
    if (o == 2'd1) return s ? "R9" : "R4";
    if (o == 2'd2 && !s) return "R5";
    if (o == 2'd2 && ins) return "R7";
    if (o == 2'd2) return "R8";
    return "R3";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] o, input logic s, input logic t, input logic ins,
      input logic atp, input logic pm, input logic [7:0] arr, input string tag);
    logic [7:0] e;
    logic ea, eb;
    @(negedge clk);
    op = o; suspended = s; timeout = t; in_susp_sector = ins;
    at_prog_addr = atp; prog_msb = pm; array_data = arr; rd_strobe = 1'b1;
    ea = (o != m_prev_op) ? 1'b0 : m_a;
    eb = (o != m_prev_op) ? 1'b0 : m_b;
    e = exp_word(o, s, t, ins, atp, pm, arr, ea, eb);
    m_a = ea ^ (o == 2'd1 || o == 2'd2);
    m_b = eb ^ flip_b_of(o, s, ins, atp);
    m_prev_op = o;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(tag, dq, e);
    chk("R2", {7'd0, dq_valid}, 8'd1);
    @(negedge clk);
    chk("R2", {7'd0, dq_valid}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1", dq, 8'h00);
    chk("R1", {7'd0, dq_valid}, 8'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_read(2'd0, 0, 1, 0, 0, 0, 8'hA5, "R3");
    do_read(2'd3, 1, 1, 1, 1, 1, 8'h3C, "R3");
    // R12 read in the cycle the program begins, then R6 sequence 0,1,0
    do_read(2'd1, 0, 0, 0, 0, 1, 8'hFF, "R12");
    do_read(2'd1, 0, 0, 0, 0, 1, 8'hFF, "R6");
    do_read(2'd1, 0, 1, 0, 0, 0, 8'hFF, "R10");
    // R5 erase, toggle B advancing
    do_read(2'd2, 0, 0, 0, 0, 0, 8'h00, "R5");
    do_read(2'd2, 0, 0, 1, 0, 0, 8'h00, "R5");
    do_read(2'd2, 0, 1, 0, 0, 0, 8'h00, "R10");
    // R7 / R8 erase suspend
    do_read(2'd2, 1, 0, 1, 0, 0, 8'h12, "R7");
    do_read(2'd2, 1, 0, 0, 0, 0, 8'h34, "R8");
    do_read(2'd2, 1, 0, 1, 0, 0, 8'h56, "R7");
    // R9 / R13 program inside suspend
    do_read(2'd1, 1, 0, 1, 1, 0, 8'h00, "R13");
    do_read(2'd1, 1, 0, 1, 0, 0, 8'h00, "R9");
    do_read(2'd1, 1, 0, 1, 0, 0, 8'h00, "R9");
    do_read(2'd1, 1, 0, 0, 0, 1, 8'h00, "R9");
    // R12: op change without a read clears the toggles
    @(negedge clk); op = 2'd2; suspended = 1'b0;
    @(negedge clk); op = 2'd1; m_prev_op = 2'd1; m_a = 1'b0; m_b = 1'b0;
    @(negedge clk);
    do_read(2'd1, 0, 0, 0, 0, 0, 8'h00, "R12");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] o;
      o = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : op;
      do_read(o, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
              1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
              tag_of(o, suspended, in_susp_sector));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule